// File: doc/BRIEF.md
# Booth-Wallace Complex Multiplier

This block forms the exact product of two signed complex numbers. The operands are X = x_re + j·x_im and Y = y_re + j·y_im. The result has a real part x_re·y_re − x_im·y_im and an imaginary part x_re·y_im + x_im·y_re.

The block builds each of the four real products itself rather than using a multiply operator. Radix-4 Booth recoding forms the partial-product rows, a tree of 3:2 carry-save adders compresses them, and a single carry-propagate adder resolves each product. One subtractor and one adder then combine the four products. The results are full precision, with no rounding or saturation.

Each operand set arrives with a valid strobe. The block registers the operands, computes the result combinationally and registers it at the output. A result with its valid flag therefore appears two clock cycles after the strobe. Results stay on the outputs until the next valid result replaces them.

Top module: `booth_cmul`

## Requirements
- R1: While reset is high and in the cycle after it, `out_vld` is 0 and both `p_re` and `p_im` are 0.
- R2: `out_vld` is high in exactly those cycles that come two rising clock edges after a cycle with `in_vld` high.
- R3: When `out_vld` is high, `p_re` equals x_re·y_re − x_im·y_im, exactly, as a 33-bit two's-complement value. The operands are those presented with the matching `in_vld`.
- R4: When `out_vld` is high, `p_im` equals x_re·y_im + x_im·y_re, exactly, as a 33-bit two's-complement value. The operands are the same ones as in R3.
- R5: When all four operands are −32768, the result is `p_re` = 0 and `p_im` = +2^31. Each real product is then +2^30.
- R6: An operand set presented while `in_vld` is low is ignored. `p_re` and `p_im` keep the last valid result.
- R7: With `x_im` = `y_im` = 0, `p_re` equals the signed product x_re·y_re and `p_im` is 0. This holds for operands at the extremes −32768 and +32767 and for alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand strobe |
| x_re | input | 16 | Real part of X, signed |
| x_im | input | 16 | Imaginary part of X, signed |
| y_re | input | 16 | Real part of Y, signed |
| y_im | input | 16 | Imaginary part of Y, signed |
| out_vld | output | 1 | Result valid, two cycles after `in_vld` |
| p_re | output | 33 | Real part of X·Y, signed |
| p_im | output | 33 | Imaginary part of X·Y, signed |

## Verification
The hardest cases are the Booth digit −2 in the top group and the +2^30 product of two −32768 operands. They depend on precise multiplier bit patterns that random small values rarely reach. The stimulus therefore draws every operand from a fixed set of sixteen values: both extremes, ±1, ±2, powers of two and alternating-bit words. It sweeps all 65536 combinations back to back. Idle cycles are inserted periodically between them, so the hold-on-invalid behaviour is also exercised under a full pipeline.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
    localparam int OP_W   = 16;
    localparam int PROD_W = 2 * OP_W;
    localparam int OUT_W  = PROD_W + 1;
    localparam int NDIG   = OP_W / 2;
    localparam int NROWS  = NDIG + 1;   // Booth rows plus one row of negation carries

    typedef struct packed {
        logic zero;
        logic two;
        logic neg;
    } booth_sel_t;

    typedef struct packed {
        logic signed [OP_W-1:0] re;
        logic signed [OP_W-1:0] im;
    } cplx_t;

    function automatic booth_sel_t booth_decode(input logic [2:0] grp);
        booth_sel_t s;
        s = '{zero: 1'b0, two: 1'b0, neg: 1'b0};
        case (grp)
            3'b000, 3'b111: s.zero = 1'b1;
            3'b001, 3'b010: s = '{zero: 1'b0, two: 1'b0, neg: 1'b0};
            3'b011:         s.two  = 1'b1;
            3'b100:         s = '{zero: 1'b0, two: 1'b1, neg: 1'b1};
            default:        s.neg  = 1'b1;   // 101, 110
        endcase
        return s;
    endfunction

    function automatic int csa_next(input int n);
        return (n / 3) * 2 + (n % 3);
    endfunction

    function automatic int csa_rows_at(input int n, input int stage);
        int r;
        r = n;
        for (int k = 0; k < stage; k++) r = csa_next(r);
        return r;
    endfunction

    function automatic int csa_stages(input int n);
        int r;
        int s;
        r = n;
        s = 0;
        while (r > 2) begin
            r = csa_next(r);
            s++;
        end
        return s;
    endfunction
endpackage

// File: rtl/booth_row_gen.sv
module booth_row_gen
    import cmul_pkg::*;
#(
    parameter int N  = OP_W,
    parameter int W  = 2 * N,
    parameter int ND = N / 2
) (
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] mplier,
    output logic [W-1:0] rows [ND+1]
);
    logic [N:0]   mp_ext;
    logic [W-1:0] x_ext;
    logic [W-1:0] neg_bits;

    assign mp_ext = {mplier, 1'b0};
    assign x_ext  = {{(W-N){mcand[N-1]}}, mcand};

    for (genvar i = 0; i < ND; i++) begin : g_dig
        booth_sel_t   sel;
        logic [W-1:0] mag;
        logic [W-1:0] cond;
        assign sel  = booth_decode(mp_ext[2*i+2 -: 3]);
        assign mag  = sel.zero ? '0 : (sel.two ? (x_ext << 1) : x_ext);
        assign cond = sel.neg ? ~mag : mag;
        assign rows[i] = cond << (2 * i);
        assign neg_bits[2*i]   = sel.neg;
        assign neg_bits[2*i+1] = 1'b0;
    end
    for (genvar k = 2 * ND; k < W; k++) begin : g_pad
        assign neg_bits[k] = 1'b0;
    end
    assign rows[ND] = neg_bits;
endmodule

// File: rtl/csa_tree.sv
module csa_tree
    import cmul_pkg::*;
#(
    parameter int W = PROD_W,
    parameter int N = NROWS
) (
    input  logic [W-1:0] rows [N],
    output logic [W-1:0] sum_row,
    output logic [W-1:0] car_row
);
    localparam int NSTG = csa_stages(N);

    logic [W-1:0] lvl [NSTG+1][N];

    for (genvar r = 0; r < N; r++) begin : g_in
        assign lvl[0][r] = rows[r];
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
        localparam int CUR = csa_rows_at(N, s);
        localparam int NXT = csa_rows_at(N, s + 1);
        localparam int GRP = CUR / 3;
        for (genvar g = 0; g < GRP; g++) begin : g_csa
            logic [W-1:0] a, b, c;
            assign a = lvl[s][3*g];
            assign b = lvl[s][3*g+1];
            assign c = lvl[s][3*g+2];
            assign lvl[s+1][2*g]   = a ^ b ^ c;
            assign lvl[s+1][2*g+1] = ((a & b) | (a & c) | (b & c)) << 1;
        end
        for (genvar r = 0; r < CUR % 3; r++) begin : g_pass
            assign lvl[s+1][2*GRP+r] = lvl[s][3*GRP+r];
        end
        for (genvar r = NXT; r < N; r++) begin : g_tie
            assign lvl[s+1][r] = '0;
        end
    end

    assign sum_row = lvl[NSTG][0];
    assign car_row = lvl[NSTG][1];
endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import cmul_pkg::*;
#(
    parameter int N = OP_W,
    parameter int W = 2 * N
) (
    input  logic [N-1:0] mcand,
    input  logic [N-1:0] mplier,
    output logic [W-1:0] prod
);
    localparam int ND = N / 2;

    logic [W-1:0] pp [ND+1];
    logic [W-1:0] s_row;
    logic [W-1:0] c_row;

    booth_row_gen #(.N(N), .W(W), .ND(ND)) u_rows (
        .mcand (mcand),
        .mplier(mplier),
        .rows  (pp)
    );

    csa_tree #(.W(W), .N(ND + 1)) u_tree (
        .rows   (pp),
        .sum_row(s_row),
        .car_row(c_row)
    );

    assign prod = s_row + c_row;   // single carry-propagate adder
endmodule

// File: rtl/booth_cmul.sv
module booth_cmul
    import cmul_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [OP_W-1:0]  x_re,
    input  logic signed [OP_W-1:0]  x_im,
    input  logic signed [OP_W-1:0]  y_re,
    input  logic signed [OP_W-1:0]  y_im,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] p_re,
    output logic signed [OUT_W-1:0] p_im
);
    cplx_t  xq, yq;
    logic   vq;

    always_ff @(posedge clk) begin
        if (rst) begin
            xq <= '0;
            yq <= '0;
            vq <= 1'b0;
        end else begin
            vq <= in_vld;
            if (in_vld) begin
                xq <= '{re: x_re, im: x_im};
                yq <= '{re: y_re, im: y_im};
            end
        end
    end

    logic [PROD_W-1:0] prd [4];
    logic [OP_W-1:0]   mc  [4];
    logic [OP_W-1:0]   ml  [4];

    // 0: re*re, 1: im*im, 2: re*im, 3: im*re
    assign mc[0] = xq.re;  assign ml[0] = yq.re;
    assign mc[1] = xq.im;  assign ml[1] = yq.im;
    assign mc[2] = xq.re;  assign ml[2] = yq.im;
    assign mc[3] = xq.im;  assign ml[3] = yq.re;

    for (genvar m = 0; m < 4; m++) begin : g_mul
        booth_mult #(.N(OP_W), .W(PROD_W)) u_mul (
            .mcand (mc[m]),
            .mplier(ml[m]),
            .prod  (prd[m])
        );
    end

    logic [OUT_W-1:0] re_d, im_d;
    assign re_d = {prd[0][PROD_W-1], prd[0]} - {prd[1][PROD_W-1], prd[1]};
    assign im_d = {prd[2][PROD_W-1], prd[2]} + {prd[3][PROD_W-1], prd[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            p_re    <= '0;
            p_im    <= '0;
        end else begin
            out_vld <= vq;
            if (vq) begin
                p_re <= re_d;
                p_im <= im_d;
            end
        end
    end
endmodule

// File: rtl/cmul_checker.sv
module cmul_checker
    import cmul_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_vld,
    input logic signed [OP_W-1:0]  x_re,
    input logic signed [OP_W-1:0]  x_im,
    input logic signed [OP_W-1:0]  y_re,
    input logic signed [OP_W-1:0]  y_im,
    input logic                    out_vld,
    input logic signed [OUT_W-1:0] p_re,
    input logic signed [OUT_W-1:0] p_im
);
    logic                    sv1, sv2;
    logic signed [OP_W-1:0]  s_a, s_b, s_c, s_d;
    logic signed [OUT_W-1:0] ref_re, ref_im;

    always_ff @(posedge clk) begin
        if (rst) begin
            sv1 <= 1'b0; sv2 <= 1'b0;
            s_a <= '0; s_b <= '0; s_c <= '0; s_d <= '0;
            ref_re <= '0; ref_im <= '0;
        end else begin
            sv1 <= in_vld;
            sv2 <= sv1;
            if (in_vld) begin
                s_a <= x_re; s_b <= x_im; s_c <= y_re; s_d <= y_im;
            end
            if (sv1) begin
                ref_re <= OUT_W'(s_a * s_c) - OUT_W'(s_b * s_d);
                ref_im <= OUT_W'(s_a * s_d) + OUT_W'(s_b * s_c);
            end
        end
    end

    p_reset_r1: assert property (@(posedge clk) $past(rst) |-> (!out_vld && p_re == 0 && p_im == 0));
    p_vld_lat_r2: assert property (@(posedge clk) disable iff (rst) out_vld == sv2);
    p_real_r3: assert property (@(posedge clk) disable iff (rst) out_vld |-> p_re == ref_re);
    p_imag_r4: assert property (@(posedge clk) disable iff (rst) out_vld |-> p_im == ref_im);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst) !sv2 |-> ($stable(p_re) && $stable(p_im)));
endmodule

bind booth_cmul cmul_checker u_chk (.*);

// File: tb/tb_booth_cmul.sv
module tb_booth_cmul;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic out_vld;
    logic signed [32:0] p_re, p_im;

    int n_chk = 0;
    int n_fail = 0;

    booth_cmul dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    logic    pv [2];
    longint  pre [2];
    longint  pim [2];
    longint  hold_re = 0, hold_im = 0;

    function automatic logic signed [15:0] pick(input int i);
        case (i)
            0: return -16'sd32768;   1: return -16'sd32767;
            2: return -16'sd16384;   3: return -16'sd2;
            4: return -16'sd1;       5: return 16'sd0;
            6: return 16'sd1;        7: return 16'sd2;
            8: return 16'sd3;        9: return 16'sd5;
            10: return 16'sh5555;    11: return -16'sh5556;
            12: return 16'sd127;     13: return -16'sd128;
            14: return 16'sd32767;   default: return 16'sd12345;
        endcase
    endfunction

    // One cycle: check outputs due now, then present a new operand set.
    task automatic step(input logic v, input logic signed [15:0] a, b, c, d);
        logic  ev;
        @(negedge clk);
        ev = pv[1];
        if (ev) begin hold_re = pre[1]; hold_im = pim[1]; end
        n_chk++;
        if (out_vld !== ev) begin
            n_fail++;
            $display("FAIL R2 out_vld=%0b expected %0b", out_vld, ev);
        end else if (longint'(p_re) != hold_re) begin
            n_fail++;
            $display("FAIL %s p_re=%0d expected %0d", ev ? "R3/R7" : "R6", p_re, hold_re);
        end else if (longint'(p_im) != hold_im) begin
            n_fail++;
            $display("FAIL %s p_im=%0d expected %0d", ev ? "R4/R7" : "R6", p_im, hold_im);
        end
        pv[1] = pv[0]; pre[1] = pre[0]; pim[1] = pim[0];
        pv[0] = v;
        pre[0] = longint'(a) * longint'(c) - longint'(b) * longint'(d);
        pim[0] = longint'(a) * longint'(d) + longint'(b) * longint'(c);
        in_vld = v; x_re = a; x_im = b; y_re = c; y_im = d;
    endtask

    initial begin
        pv[0] = 0; pv[1] = 0; pre[0] = 0; pre[1] = 0; pim[0] = 0; pim[1] = 0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        n_chk++;
        if (out_vld !== 1'b0 || p_re !== 33'sd0 || p_im !== 33'sd0) begin
            n_fail++;
            $display("FAIL R1 vld=%0b re=%0d im=%0d expected 0 0 0", out_vld, p_re, p_im);
        end
        rst = 1'b0;

        // R5: all operands at the negative extreme
        step(1'b1, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768);
        step(1'b0, 16'sd7, 16'sd7, 16'sd7, 16'sd7);
        step(1'b0, 16'sd0, 16'sd0, 16'sd0, 16'sd0);
        n_chk++;
        if (p_re !== 33'sd0 || p_im !== 33'sd2147483648) begin
            n_fail++;
            $display("FAIL R5 re=%0d im=%0d expected 0 2147483648", p_re, p_im);
        end

        // R7: purely real operands at extremes
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                step(1'b1, pick(i), 16'sd0, pick(j), 16'sd0);

        // R3, R4, R6: full sweep with idle gaps
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                for (int k = 0; k < 16; k++)
                    for (int l = 0; l < 16; l++) begin
                        step(1'b1, pick(i), pick(j), pick(k), pick(l));
                        if (((i + j + k + l) % 7) == 0)
                            step(1'b0, pick(l), pick(k), pick(j), pick(i));
                    end
        step(1'b0, 16'sd0, 16'sd0, 16'sd0, 16'sd0);
        step(1'b0, 16'sd0, 16'sd0, 16'sd0, 16'sd0);
        step(1'b0, 16'sd0, 16'sd0, 16'sd0, 16'sd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule